// File: doc/BRIEF.md
# Time-of-Flight Line Sensor Drive Sequencer

This block produces every digital control pulse that a linear time-of-flight image sensor needs, all from one fast system clock. It divides that clock by four to make the sensor master clock. On a start command it runs one frame: a pixel reset pulse, then an integration window in which three transfer-gate clocks fire in turn, then a sampling pulse, then a gap, then a readout trigger placed at a fixed phase of the master clock, and finally a run of master clock periods, one for each pixel read out.

Every duration is a runtime input counted in system-clock cycles. Each is raised to a minimum that is set by a parameter, so a low setting can never break the sensor's timing limits. The transfer-gate interval and each gate's high time are parameters. A gate whose high time is zero is built as a constant low. The host pulses `start_i` while `busy_o` is low, holds the settings steady while `busy_o` is high, and sees `done_o` pulse once, on the master clock edge that reads the last pixel.

Top module: `tof_line_seq`

## Requirements
- R1: `mclk_o` is low while reset is held. After reset is released it runs free, high for two system cycles and low for two.
- R2: A `start_i` sampled high while `busy_o` is low sets `busy_o` and `pres_o` on the next cycle. A `start_i` sampled while `busy_o` is high has no effect: the running frame keeps its timing and no second frame follows.
- R3: `pres_o` stays high for exactly max(`rst_len_i`, RST_MIN) cycles.
- R4: Integration starts on the cycle after `pres_o` falls and lasts max(`int_cnt_i`,1)×TX_PER cycles. In each interval, `txg_o[0]` is high for its first TX_G1 cycles, `txg_o[1]` for the next TX_G2 cycles and `txg_o[2]` for the next TX_G3 cycles. No two gates are high together, and all gates are low outside integration.
- R5: `samp_o` rises on the first cycle after integration and stays high for exactly max(`samp_len_i`, SAMP_MIN) cycles.
- R6: With G = max(`gap_len_i`, GAP_MIN), the number of low cycles between the fall of `samp_o` and the rise of `trig_o` is between G+1 and G+4.
- R7: Each edge of `trig_o` comes one system cycle after a rising edge of `mclk_o`, so `mclk_o` is high in that cycle and the one before it, and low two cycles before. `trig_o` stays high for exactly four cycles.
- R8: After `trig_o` falls, exactly max(`npix_i`,1) rising edges of `mclk_o` are issued. `done_o` is high for one cycle, on the cycle of the last of those edges.
- R9: `busy_o` stays high for four cycles, counting the `done_o` cycle, then goes low.
- R10: Pulling `rst_n` low at once forces every output low and abandons the frame. After release, `busy_o` stays low until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start command |
| rst_len_i | input | DUR_W | Pixel reset length in cycles |
| int_cnt_i | input | INT_W | Number of transfer-gate intervals |
| samp_len_i | input | DUR_W | Sampling pulse length in cycles |
| gap_len_i | input | DUR_W | Minimum gap from sampling fall to trigger |
| npix_i | input | PIX_W | Number of pixels read out |
| mclk_o | output | 1 | Sensor master clock |
| pres_o | output | 1 | Pixel reset pulse |
| samp_o | output | 1 | Signal sampling pulse |
| trig_o | output | 1 | Readout trigger pulse |
| txg_o | output | 3 | Transfer-gate clocks 1..3 |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last pixel issued strobe |

## Verification
The bench builds the block with DUR_W=8, INT_W=4, PIX_W=6, RST_MIN=8, SAMP_MIN=4, GAP_MIN=5, TX_PER=8 and gate high times of 3, 3 and 1. These short minimums let frames with settings below the floor, and with zero settings, reach the clamping quickly. A nonzero third gate with one spare cycle per interval exercises all three gate slots and the idle slot. The narrow count widths let the largest interval count (15) and the largest pixel count (63) run within a few hundred cycles.

// File: rtl/tof_line_pkg.sv
package tof_line_pkg;

  localparam int MCLK_DIV = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST,
    S_INTEG,
    S_SAMP,
    S_GAP,
    S_ALIGN,
    S_TRIG,
    S_READ,
    S_TAIL
  } seq_state_e;

  function automatic logic [31:0] at_least(input logic [31:0] v, input logic [31:0] lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/tof_mclk_div.sv
module tof_mclk_div (
  input  logic       clk,
  input  logic       rst_n,
  output logic [1:0] ph_o,
  output logic       mclk_o
);
  logic [1:0] ph_q;
  logic [1:0] ph_n;

  always_comb begin
    ph_n = ph_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 2'b10;
    else        ph_q <= ph_n;
  end

  // single flop bit drives the clock: glitch free, 50 % duty
  assign mclk_o = ~ph_q[1];
  assign ph_o   = ph_q;
endmodule

// File: rtl/tof_dcount.sv
module tof_dcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld | dec;
    if (ld) cnt_n = ld_val;
    else    cnt_n = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/tof_txg_gen.sv
module tof_txg_gen #(
  parameter int PER = 6,
  parameter int G1  = 3,
  parameter int G2  = 3,
  parameter int G3  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_n,
  output logic [2:0] gate_o,
  output logic       wrap_o
);
  localparam int PW = $clog2(PER + 1);

  logic          run_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_n;

  always_comb begin
    if (!run_n || !run_q)           pos_n = '0;
    else if (pos_q == PW'(PER - 1)) pos_n = '0;
    else                            pos_n = pos_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
    end else begin
      run_q <= run_n;
      pos_q <= pos_n;
    end
  end

  assign wrap_o = run_q && (pos_q == PW'(PER - 1));

  for (genvar gi = 0; gi < 3; gi++) begin : g_gate
    localparam int LO = (gi == 0) ? 0 : ((gi == 1) ? G1 : G1 + G2);
    localparam int HI = LO + ((gi == 0) ? G1 : ((gi == 1) ? G2 : G3));
    if (HI > LO) begin : g_on
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= run_n && (int'(pos_n) >= LO) && (int'(pos_n) < HI);
      end
      assign gate_o[gi] = q;
    end else begin : g_off
      assign gate_o[gi] = 1'b0;
    end
  end
endmodule

// File: rtl/tof_line_seq.sv
module tof_line_seq #(
  parameter int DUR_W    = 16,
  parameter int INT_W    = 12,
  parameter int PIX_W    = 10,
  parameter int RST_MIN  = 1000,
  parameter int SAMP_MIN = 100,
  parameter int GAP_MIN  = 120,
  parameter int TX_PER   = 6,
  parameter int TX_G1    = 3,
  parameter int TX_G2    = 3,
  parameter int TX_G3    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DUR_W-1:0] rst_len_i,
  input  logic [INT_W-1:0] int_cnt_i,
  input  logic [DUR_W-1:0] samp_len_i,
  input  logic [DUR_W-1:0] gap_len_i,
  input  logic [PIX_W-1:0] npix_i,
  output logic             mclk_o,
  output logic             pres_o,
  output logic             samp_o,
  output logic             trig_o,
  output logic [2:0]       txg_o,
  output logic             busy_o,
  output logic             done_o
);
  import tof_line_pkg::*;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // settings raised to their floors
  logic [DUR_W-1:0] rst_eff, samp_eff, gap_eff;
  logic [INT_W-1:0] int_eff;
  logic [PIX_W-1:0] pix_eff;
  always_comb begin
    rst_eff  = DUR_W'(at_least(32'(rst_len_i), RST_MIN));
    samp_eff = DUR_W'(at_least(32'(samp_len_i), SAMP_MIN));
    gap_eff  = DUR_W'(at_least(32'(gap_len_i), GAP_MIN));
    int_eff  = INT_W'(at_least(32'(int_cnt_i), 1));
    pix_eff  = PIX_W'(at_least(32'(npix_i), 1));
  end

  logic [1:0] ph;
  tof_mclk_div u_mclk (.clk(clk), .rst_n(rst_i), .ph_o(ph), .mclk_o(mclk_o));

  logic             dur_ld, dur_dec, dur_zero;
  logic [DUR_W-1:0] dur_val;
  logic             ic_ld, ic_dec, ic_zero;
  logic             pc_ld, pc_dec, pc_zero;

  tof_dcount #(.W(DUR_W)) u_dur (.clk(clk), .rst_n(rst_i), .ld(dur_ld), .ld_val(dur_val),
                                 .dec(dur_dec), .zero(dur_zero));
  tof_dcount #(.W(INT_W)) u_icnt (.clk(clk), .rst_n(rst_i), .ld(ic_ld),
                                  .ld_val(int_eff - INT_W'(1)), .dec(ic_dec), .zero(ic_zero));
  tof_dcount #(.W(PIX_W)) u_pcnt (.clk(clk), .rst_n(rst_i), .ld(pc_ld),
                                  .ld_val(pix_eff - PIX_W'(1)), .dec(pc_dec), .zero(pc_zero));

  seq_state_e state_q, state_n;
  logic       tx_wrap;

  tof_txg_gen #(.PER(TX_PER), .G1(TX_G1), .G2(TX_G2), .G3(TX_G3)) u_txg (
    .clk(clk), .rst_n(rst_i), .run_n(state_n == S_INTEG), .gate_o(txg_o), .wrap_o(tx_wrap)
  );

  always_comb begin
    state_n = state_q;
    dur_ld  = 1'b0;
    dur_dec = 1'b0;
    dur_val = '0;
    ic_ld   = 1'b0;
    ic_dec  = 1'b0;
    pc_ld   = 1'b0;
    pc_dec  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_n = S_RST;
        dur_ld  = 1'b1;
        dur_val = rst_eff - DUR_W'(1);
      end
      S_RST: if (dur_zero) begin
        state_n = S_INTEG;
        ic_ld   = 1'b1;
      end else dur_dec = 1'b1;
      S_INTEG: if (tx_wrap) begin
        if (ic_zero) begin
          state_n = S_SAMP;
          dur_ld  = 1'b1;
          dur_val = samp_eff - DUR_W'(1);
        end else ic_dec = 1'b1;
      end
      S_SAMP: if (dur_zero) begin
        state_n = S_GAP;
        dur_ld  = 1'b1;
        dur_val = gap_eff - DUR_W'(1);
      end else dur_dec = 1'b1;
      S_GAP: if (dur_zero) state_n = S_ALIGN;
             else          dur_dec = 1'b1;
      // trigger edges land one system cycle after an mclk rise
      S_ALIGN: if (ph == 2'd0) state_n = S_TRIG;
      S_TRIG: if (ph == 2'd0) begin
        state_n = S_READ;
        pc_ld   = 1'b1;
      end
      S_READ: if (ph == 2'd3) begin
        if (pc_zero) begin
          state_n = S_TAIL;
          dur_ld  = 1'b1;
          dur_val = DUR_W'(MCLK_DIV - 1);
        end else pc_dec = 1'b1;
      end
      S_TAIL: if (dur_zero) state_n = S_IDLE;
              else          dur_dec = 1'b1;
      default: state_n = S_IDLE;
    endcase
  end

  logic pres_q, samp_q, trig_q, busy_q, done_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= S_IDLE;
      pres_q  <= 1'b0;
      samp_q  <= 1'b0;
      trig_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pres_q  <= (state_n == S_RST);
      samp_q  <= (state_n == S_SAMP);
      trig_q  <= (state_n == S_TRIG);
      busy_q  <= (state_n != S_IDLE);
      done_q  <= (state_q == S_READ) && (state_n == S_TAIL);
    end
  end

  assign pres_o = pres_q;
  assign samp_o = samp_q;
  assign trig_o = trig_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/tof_line_seq_chk.sv
module tof_line_seq_chk #(
  parameter int RST_MIN  = 1000,
  parameter int SAMP_MIN = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mclk,
  input logic       pres,
  input logic       samp,
  input logic       trig,
  input logic [2:0] txg,
  input logic       busy,
  input logic       done
);
  logic [31:0] pres_run, samp_run, trig_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_run <= '0;
      samp_run <= '0;
      trig_run <= '0;
    end else begin
      pres_run <= pres ? pres_run + 32'd1 : '0;
      samp_run <= samp ? samp_run + 32'd1 : '0;
      trig_run <= trig ? trig_run + 32'd1 : '0;
    end
  end

  assert_mclk_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk) |=> mclk);
  assert_mclk_lo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk) |=> !mclk);
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres) |-> !$past(busy));
  assert_pres_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pres) |-> (pres_run >= RST_MIN));
  assert_gate_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(txg) <= 1);
  assert_gate_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txg != 3'b000) |-> (!pres && !samp && !trig));
  assert_samp_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(samp) |-> (samp_run >= SAMP_MIN));
  assert_trig_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trig) || $fell(trig)) |-> (mclk && $past(mclk) && !$past(mclk, 2)));
  assert_trig_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig) |-> (trig_run == 32'd4));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_mclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mclk && !$past(mclk)));
  assert_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done, 4));
endmodule

bind tof_line_seq tof_line_seq_chk #(.RST_MIN(RST_MIN), .SAMP_MIN(SAMP_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .mclk(mclk_o), .pres(pres_o), .samp(samp_o), .trig(trig_o),
  .txg(txg_o), .busy(busy_o), .done(done_o)
);

// File: tb/tb_tof_line_seq.sv
module tb_tof_line_seq;
  localparam int DUR_W = 8, INT_W = 4, PIX_W = 6;
  localparam int PER = 8, G1 = 3, G2 = 3, G3 = 1;
  localparam int NV = 5;
  // stimulus
  localparam int V_RST [NV] = '{10, 3, 8, 20, 0};
  localparam int V_INT [NV] = '{2, 0, 3, 1, 15};
  localparam int V_SMP [NV] = '{6, 1, 4, 9, 0};
  localparam int V_GAP [NV] = '{7, 2, 5, 12, 0};
  localparam int V_PIX [NV] = '{3, 0, 5, 2, 63};
  // expected after floors (RST 8, SAMP 4, GAP 5, INT 1, PIX 1)
  localparam int E_RST [NV] = '{10, 8, 8, 20, 8};
  localparam int E_INT [NV] = '{2, 1, 3, 1, 15};
  localparam int E_SMP [NV] = '{6, 4, 4, 9, 4};
  localparam int E_GAP [NV] = '{7, 5, 5, 12, 5};
  localparam int E_PIX [NV] = '{3, 1, 5, 2, 63};

  logic clk, rst_n, start;
  logic [DUR_W-1:0] rst_len, samp_len, gap_len;
  logic [INT_W-1:0] int_cnt;
  logic [PIX_W-1:0] npix;
  logic mclk, pres, samp, trig, busy, done;
  logic [2:0] txg;
  int ntests = 0, nfail = 0;

  tof_line_seq #(.DUR_W(DUR_W), .INT_W(INT_W), .PIX_W(PIX_W), .RST_MIN(8), .SAMP_MIN(4),
                 .GAP_MIN(5), .TX_PER(PER), .TX_G1(G1), .TX_G2(G2), .TX_G3(G3)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rst_len_i(rst_len), .int_cnt_i(int_cnt),
    .samp_len_i(samp_len), .gap_len_i(gap_len), .npix_i(npix), .mclk_o(mclk), .pres_o(pres),
    .samp_o(samp), .trig_o(trig), .txg_o(txg), .busy_o(busy), .done_o(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    ntests++;
    if (act < lo || act > hi) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic run_frame(input int v, input bit poke);
    int stage = 0, nres = 0, nint = 0, nsmp = 0, ngap = 0, ntrg = 0, npx = 0;
    int g1 = 0, g2 = 0, g3 = 0, ovl = 0, leak = 0, albad = 0, cyc = 0, tail = 0;
    bit got_done = 0, poked = 0;
    logic pm1, pm2;
    rst_len  = DUR_W'(V_RST[v]);
    int_cnt  = INT_W'(V_INT[v]);
    samp_len = DUR_W'(V_SMP[v]);
    gap_len  = DUR_W'(V_GAP[v]);
    npix     = PIX_W'(V_PIX[v]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3", "pres one cycle after start", int'(pres), 1);
    chk("R2", "busy one cycle after start", int'(busy), 1);
    pm1 = mclk; pm2 = mclk;
    while (!got_done && cyc < 4000) begin
      if (stage == 0 && !pres) stage = 1;
      if (stage == 1 && samp) stage = 2;
      if (stage == 2 && !samp) stage = 3;
      if (stage == 3 && trig) begin stage = 4; if (!(mclk && pm1 && !pm2)) albad++; end
      if (stage == 4 && !trig) begin stage = 5; if (!(mclk && pm1 && !pm2)) albad++; end
      if (pres) nres++;
      if (stage == 1) nint++;
      if (samp) nsmp++;
      if (stage == 3) ngap++;
      if (trig) ntrg++;
      if (stage == 5 && mclk && !pm1) npx++;
      g1 += int'(txg[0]); g2 += int'(txg[1]); g3 += int'(txg[2]);
      if ($countones(txg) > 1) ovl++;
      if (txg != 3'b000 && stage != 1) leak++;
      if (poke && stage == 5 && !poked) begin start = 1'b1; poked = 1; end
      else start = 1'b0;
      if (done) got_done = 1;
      else begin
        pm2 = pm1; pm1 = mclk;
        @(negedge clk); cyc++;
      end
    end
    start = 1'b0;
    chk("R3", "pres high cycles", nres, E_RST[v]);
    chk("R4", "integration cycles", nint, E_INT[v] * PER);
    chk("R4", "gate1 high cycles", g1, E_INT[v] * G1);
    chk("R4", "gate2 high cycles", g2, E_INT[v] * G2);
    chk("R4", "gate3 high cycles", g3, E_INT[v] * G3);
    chk("R4", "gate overlaps", ovl, 0);
    chk("R4", "gate outside integration", leak, 0);
    chk("R5", "samp high cycles", nsmp, E_SMP[v]);
    chk_rng("R6", "samp fall to trig rise", ngap, E_GAP[v] + 1, E_GAP[v] + 4);
    chk("R7", "trig high cycles", ntrg, 4);
    chk("R7", "trig edge phase errors", albad, 0);
    chk("R8", "done seen", int'(got_done), 1);
    chk("R8", "mclk rises after trig", npx, E_PIX[v]);
    while (busy && tail < 20) begin tail++; @(negedge clk); end
    chk("R9", "busy cycles from done", tail, 4);
    if (poke) begin
      int nb = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); nb += int'(busy); end
      chk("R2", "busy after ignored start", nb, 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    start = 1'b0; rst_len = '0; samp_len = '0; gap_len = '0; int_cnt = '0; npix = '0;
    rst_n = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "outputs in reset", int'({pres, samp, trig, txg, busy, done}), 0);
    chk("R1", "mclk in reset", int'(mclk), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    begin
      int hi = 0, bad = 0;
      logic p1, p2;
      p1 = mclk; p2 = ~mclk;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        hi += int'(mclk);
        if (i >= 1 && mclk == p2) bad++;
        p2 = p1; p1 = mclk;
      end
      chk("R1", "mclk high samples of 16", hi, 8);
      chk("R1", "mclk half-period errors", bad, 0);
    end
    for (int v = 0; v < NV; v++) run_frame(v, v == 2);
    // asynchronous reset in the middle of a frame
    rst_len = 8'd20;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    #3 rst_n = 1'b0;
    #1 chk("R10", "outputs right after async reset", int'({mclk, pres, samp, trig, txg, busy, done}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    begin
      int nb = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); nb += int'(busy | pres); end
      chk("R10", "busy after reset release", nb, 0);
    end
    run_frame(0, 1'b0);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule